// File: doc/BRIEF.md
# DSP Arithmetic Status Word

This block builds and holds the 16-bit status word of a data arithmetic unit that owns two 40-bit accumulators. In each cycle the arithmetic path may present one finished result as a 41-bit exact value, meaning the true result before any truncation. The result comes with a valid strobe, the number of the accumulator it is written to, and the saturation-mode setting. From that value the block registers four live flags: negative, zero, 40-bit logical overflow and 32-bit mathematical overflow. It also keeps a sticky copy of each overflow flag, and one overflowed flag per accumulator. The overflowed flag is raised only when saturation mode was off.

The low four guard bits (35:32) of each accumulator are fed in continuously and appear in the word without delay. Software reads the word through a combinational read port. It can overwrite every register-backed bit with a one-cycle write strobe, and a write beats a result that arrives in the same cycle. Reset clears only the two sticky bits. The remaining flags come up undefined and keep their value through any later reset. While reset is held, results and writes are ignored.

Top module: `dau_status_word`

## Requirements
- R1: While rst_n is low and on the first read after it, bits 11 and 10 read 0. Bits 15:12, 9 and 4 keep the value they had before reset, and neither a result nor a software write presented during reset alters them.
- R2: After a valid result without a simultaneous write, bit 15 (negative) equals 1 exactly when the 41-bit exact value, read as two's complement, is below zero.
- R3: After such a result, bit 14 (zero) equals 1 exactly when the 41-bit exact value is zero.
- R4: After such a result, bit 13 (logical overflow) equals 1 exactly when the exact value lies outside the signed 40-bit range [-2^39, 2^39-1].
- R5: After such a result, bit 12 (mathematical overflow) equals 1 exactly when the low 40 bits of the value, read as signed, lie outside the signed 32-bit range [-2^31, 2^31-1].
- R6: Bit 11 becomes 1 whenever a result sets bit 13, and bit 10 whenever a result sets bit 12. Once set, each stays 1 through any number of non-overflowing results until a software write loads it.
- R7: A software write loads bits 15:9 and bit 4 from sw_wdata on the next clock edge. Bits 8:5 and 3:0 of the write data have no effect on what is read back.
- R8: When sw_wr and res_valid are both high in one cycle, the word takes the written bits and the result is discarded.
- R9: For a result with res_dest = 0, bit 4 becomes 1 exactly when the result sets bit 12 and sat_mode is 0. For res_dest = 1 the same rule applies to bit 9.
- R10: A result aimed at one accumulator leaves the other accumulator's overflowed bit (bit 9 for res_dest = 0, bit 4 for res_dest = 1) unchanged.
- R11: Bits 8:5 always equal acc1_guard and bits 3:0 always equal acc0_guard, with no clock delay.
- R12: In a cycle with neither res_valid nor sw_wr, bits 15:9 and 4 hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears the sticky bits and freezes all updates |
| res_valid | input | 1 | A result is presented this cycle |
| res_value | input | 41 | Exact two's-complement result |
| res_dest | input | 1 | Destination accumulator of the result (0 or 1) |
| sat_mode | input | 1 | Saturation mode active for this result |
| acc0_guard | input | 4 | Bits 35:32 of accumulator 0 |
| acc1_guard | input | 4 | Bits 35:32 of accumulator 1 |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Current status word |

## Verification
The flag logic is driven with values placed just beside the signed 32-bit, 40-bit and 41-bit limits, at offsets from -2 to +2. These values separate an off-by-one in either overflow bound, and they also separate confusion between the 41-bit sign and the 40-bit sign. Every such value is repeated for both destinations and both saturation settings, which exposes a swapped accumulator or a missing gate on the per-accumulator flag. A long pseudo-random run with varying magnitudes follows. Directed sequences cover sticky retention over several clean results, clearing by a write, a write colliding with a result, idle cycles and reset during activity. An exhaustive sweep of both guard inputs covers the mirrored fields.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
    localparam int ACC_W   = 40;
    localparam int MATH_W  = 32;
    localparam int GUARD_W = 4;
    localparam int WORD_W  = 16;
    localparam int N_ACC   = 2;

    // word bit positions (software and the rest of the core decode these)
    localparam int B_NEG  = 15;
    localparam int B_ZERO = 14;
    localparam int B_LOV  = 13;
    localparam int B_MOV  = 12;
    localparam int B_SLOV = 11;
    localparam int B_SMOV = 10;
    localparam int B_A1OV = 9;
    localparam int B_A1G  = 5;
    localparam int B_A0OV = 4;
    localparam int B_A0G  = 0;

    typedef struct packed {
        logic neg;
        logic zero;
        logic lov;
        logic mov;
    } res_flags_t;
endpackage

// File: rtl/dsw_eval.sv
module dsw_eval
    import dsw_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int MW = MATH_W
) (
    input  logic [AW:0]  value,
    output res_flags_t   flags
);
    localparam int TOP_N = AW - MW + 1;

    logic [TOP_N-1:0] top_bits;

    always_comb begin
        top_bits   = value[AW-1:MW-1];
        flags.neg  = value[AW];
        flags.zero = ~|value;
        flags.lov  = value[AW] ^ value[AW-1];
        flags.mov  = ~((&top_bits) | (~|top_bits));
    end
endmodule

// File: rtl/dsw_sticky.sv
module dsw_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= 1'b0;
        else if (wr_en)  q <= wr_bit;
        else if (set_i)  q <= 1'b1;
    end

    // R6: a set sticky bit survives every cycle without a write
    p_sticky_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !wr_en) |=> q);
endmodule

// File: rtl/dsw_acc_ovf.sv
module dsw_acc_ovf (
    input  logic clk,
    input  logic upd_en,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic mov,
    input  logic sat,
    output logic ovf_q
);
    always_ff @(posedge clk) begin
        if (wr_en)       ovf_q <= wr_bit;
        else if (upd_en) ovf_q <= mov & ~sat;
    end

    // R9: saturated results never mark the accumulator overflowed
    p_sat_gate_r9: assert property (@(posedge clk)
        (upd_en && !wr_en && sat) |=> !ovf_q);
endmodule

// File: rtl/dau_status_word.sv
module dau_status_word
    import dsw_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int MW = MATH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [AW:0]       res_value,
    input  logic              res_dest,
    input  logic              sat_mode,
    input  logic [GUARD_W-1:0] acc0_guard,
    input  logic [GUARD_W-1:0] acc1_guard,
    input  logic              sw_wr,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] sw_rdata
);
    localparam longint LIM40 = longint'(1) << (AW - 1);
    localparam longint LIM32 = longint'(1) << (MW - 1);

    res_flags_t ev;
    res_flags_t live_q;
    logic       wr_eff, upd_eff;
    logic       slov_q, smov_q;
    logic [N_ACC-1:0] aov_q;
    logic       unused_wdata;

    assign unused_wdata = ^{sw_wdata[B_A1G+GUARD_W-1:B_A1G], sw_wdata[B_A0G+GUARD_W-1:B_A0G]};

    assign wr_eff  = sw_wr & rst_n;
    assign upd_eff = res_valid & rst_n & ~sw_wr;

    dsw_eval #(.AW(AW), .MW(MW)) u_eval (
        .value (res_value),
        .flags (ev)
    );

    // live flags: no reset, frozen while reset is held
    always_ff @(posedge clk) begin
        if (wr_eff) begin
            live_q.neg  <= sw_wdata[B_NEG];
            live_q.zero <= sw_wdata[B_ZERO];
            live_q.lov  <= sw_wdata[B_LOV];
            live_q.mov  <= sw_wdata[B_MOV];
        end else if (upd_eff) begin
            live_q <= ev;
        end
    end

    dsw_sticky u_slov (
        .clk (clk), .rst_n (rst_n), .set_i (upd_eff & ev.lov),
        .wr_en (wr_eff), .wr_bit (sw_wdata[B_SLOV]), .q (slov_q)
    );
    dsw_sticky u_smov (
        .clk (clk), .rst_n (rst_n), .set_i (upd_eff & ev.mov),
        .wr_en (wr_eff), .wr_bit (sw_wdata[B_SMOV]), .q (smov_q)
    );

    for (genvar i = 0; i < N_ACC; i++) begin : g_acc
        localparam int POS = (i == 0) ? B_A0OV : B_A1OV;
        dsw_acc_ovf u_ovf (
            .clk    (clk),
            .upd_en (upd_eff & (res_dest == i[0])),
            .wr_en  (wr_eff),
            .wr_bit (sw_wdata[POS]),
            .mov    (ev.mov),
            .sat    (sat_mode),
            .ovf_q  (aov_q[i])
        );
    end

    always_comb begin
        sw_rdata         = '0;
        sw_rdata[B_NEG]  = live_q.neg;
        sw_rdata[B_ZERO] = live_q.zero;
        sw_rdata[B_LOV]  = live_q.lov;
        sw_rdata[B_MOV]  = live_q.mov;
        sw_rdata[B_SLOV] = slov_q;
        sw_rdata[B_SMOV] = smov_q;
        sw_rdata[B_A1OV] = aov_q[1];
        sw_rdata[B_A0OV] = aov_q[0];
        sw_rdata[B_A1G+GUARD_W-1:B_A1G] = acc1_guard;
        sw_rdata[B_A0G+GUARD_W-1:B_A0G] = acc0_guard;
    end

    // ---------------- assertions ----------------
    logic signed [63:0] sx41, sx40;
    assign sx41 = 64'(signed'(res_value));
    assign sx40 = 64'(signed'(res_value[AW-1:0]));

    p_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !sw_wr) |=> sw_rdata[B_NEG] == $past(sx41 < 0));
    p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !sw_wr) |=> sw_rdata[B_ZERO] == $past(sx41 == 0));
    p_lov_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !sw_wr) |=> sw_rdata[B_LOV] == $past(sx41 < -LIM40 || sx41 > LIM40 - 1));
    p_mov_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !sw_wr) |=> sw_rdata[B_MOV] == $past(sx40 < -LIM32 || sx40 > LIM32 - 1));
    p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !sw_wr && (sx40 < -LIM32 || sx40 > LIM32 - 1)) |=> sw_rdata[B_SMOV]);
    p_wr_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (sw_rdata[15:9] == $past(sw_wdata[15:9])) && (sw_rdata[4] == $past(sw_wdata[4])));
    p_other_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !sw_wr && !res_dest) |=> $stable(sw_rdata[B_A1OV]));
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !sw_wr) |=> ($stable(sw_rdata[15:9]) && $stable(sw_rdata[4])));
endmodule

// File: tb/sim_dau_status_word.sv
module sim_dau_status_word;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [40:0] res_value = '0;
    logic        res_dest = 1'b0;
    logic        sat_mode = 1'b0;
    logic [3:0]  acc0_guard = '0;
    logic [3:0]  acc1_guard = '0;
    logic        sw_wr = 1'b0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model of register-backed bits
    logic e_neg, e_zero, e_lov, e_mov, e_sl, e_sm, e_o0, e_o1;

    always #(CLK_P/2) clk = ~clk;

    dau_status_word u0 (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
        .res_dest(res_dest), .sat_mode(sat_mode), .acc0_guard(acc0_guard),
        .acc1_guard(acc1_guard), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_word(input string ctx, input logic d);
        chk({ctx, " R2 neg"},  16'(sw_rdata[15]), 16'(e_neg));
        chk({ctx, " R3 zero"}, 16'(sw_rdata[14]), 16'(e_zero));
        chk({ctx, " R4 lov"},  16'(sw_rdata[13]), 16'(e_lov));
        chk({ctx, " R5 mov"},  16'(sw_rdata[12]), 16'(e_mov));
        chk({ctx, " R6 sticky"}, 16'(sw_rdata[11:10]), 16'({e_sl, e_sm}));
        chk({ctx, " R9 dest ovf"},   16'(d ? sw_rdata[9] : sw_rdata[4]), 16'(d ? e_o1 : e_o0));
        chk({ctx, " R10 other ovf"}, 16'(d ? sw_rdata[4] : sw_rdata[9]), 16'(d ? e_o0 : e_o1));
        chk({ctx, " R11 guard"}, 16'({sw_rdata[8:5], sw_rdata[3:0]}), 16'({acc1_guard, acc0_guard}));
    endtask

    function automatic logic [15:0] exp_word();
        return {e_neg, e_zero, e_lov, e_mov, e_sl, e_sm, e_o1, acc1_guard, e_o0, acc0_guard};
    endfunction

    task automatic model_res(input logic [40:0] v, input logic d, input logic s);
        longint sx, lx, l40, l32;
        sx  = longint'(signed'(v));
        lx  = longint'(signed'(v[39:0]));
        l40 = longint'(1) << 39;
        l32 = longint'(1) << 31;
        e_neg  = (sx < 0);
        e_zero = (sx == 0);
        e_lov  = (sx < -l40) || (sx > l40 - 1);
        e_mov  = (lx < -l32) || (lx > l32 - 1);
        if (e_lov) e_sl = 1'b1;
        if (e_mov) e_sm = 1'b1;
        if (d) e_o1 = e_mov & ~s; else e_o0 = e_mov & ~s;
    endtask

    task automatic model_wr(input logic [15:0] w);
        {e_neg, e_zero, e_lov, e_mov, e_sl, e_sm, e_o1} = w[15:9];
        e_o0 = w[4];
    endtask

    task automatic do_op(input logic [40:0] v, input logic d, input logic s, input string ctx);
        @(negedge clk);
        res_value = v; res_dest = d; sat_mode = s; res_valid = 1'b1;
        @(posedge clk); #1;
        res_valid = 1'b0;
        model_res(v, d, s);
        chk_word(ctx, d);
    endtask

    task automatic do_wr(input logic [15:0] w, input string ctx);
        @(negedge clk);
        sw_wdata = w; sw_wr = 1'b1;
        @(posedge clk); #1;
        sw_wr = 1'b0;
        model_wr(w);
        chk({ctx, " R7 write"}, sw_rdata, exp_word());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        longint bases [8];
        logic [63:0] lf;
        // R1: sticky bits during and after reset
        repeat (3) @(negedge clk);
        chk("R1 sticky in reset", 16'(sw_rdata[11:10]), 16'd0);
        rst_n = 1'b1;
        e_sl = 1'b0; e_sm = 1'b0;
        @(negedge clk); #1;
        chk("R1 sticky after reset", 16'(sw_rdata[11:10]), 16'd0);

        // R7: write loads flags, guard bits of write data ignored
        acc0_guard = 4'h5; acc1_guard = 4'hA;
        do_wr(16'hFFFF, "wr ones");
        do_wr(16'h0000, "wr zeros");
        do_wr(16'hA41E, "wr mix");
        chk("R7 guard ignores wdata", 16'({sw_rdata[8:5], sw_rdata[3:0]}), 16'h A5);
        do_wr(16'h0000, "wr clear");

        // boundary sweep over both destinations and saturation settings
        bases[0] = 0;
        bases[1] = longint'(1) << 31;
        bases[2] = -(longint'(1) << 31);
        bases[3] = longint'(1) << 39;
        bases[4] = -(longint'(1) << 39);
        bases[5] = (longint'(1) << 40) - 3;
        bases[6] = -(longint'(1) << 40) + 2;
        bases[7] = 12345;
        for (int b = 0; b < 8; b++)
            for (int dl = -2; dl <= 2; dl++)
                for (int m = 0; m < 4; m++) begin
                    longint sv;
                    sv = bases[b] + longint'(dl);
                    acc0_guard = 4'(b + m); acc1_guard = 4'(dl + 5);
                    do_op(sv[40:0], m[0], m[1], "sweep");
                end

        // R6: sticky retention across clean results, then clear by write
        do_wr(16'h0000, "R6 pre clear");
        do_op(41'h0_8000_0000, 1'b0, 1'b0, "R6 set mov");
        do_op(41'h100_0000_0000, 1'b1, 1'b0, "R6 set lov");
        for (int k = 0; k < 6; k++) do_op(41'(k + 1), k[0], 1'b0, "R6 hold");
        chk("R6 sticky retained", 16'(sw_rdata[11:10]), 16'b11);
        do_wr(16'h0000, "R6 clear");
        chk("R6 sticky cleared", 16'(sw_rdata[11:10]), 16'b00);

        // R9 gating: overflow with saturation on leaves flag low, off sets it
        do_op(41'h0_8000_0000, 1'b1, 1'b1, "R9 sat on");
        chk("R9 sat gate acc1", 16'(sw_rdata[9]), 16'd0);
        do_op(41'h0_8000_0000, 1'b1, 1'b0, "R9 sat off");
        chk("R9 set acc1", 16'(sw_rdata[9]), 16'd1);
        do_op(41'h0_0000_0001, 1'b0, 1'b0, "R10 acc0 clean");
        chk("R10 acc1 kept", 16'(sw_rdata[9]), 16'd1);

        // R8: write collides with an overflowing result
        @(negedge clk);
        res_value = 41'h180_0000_0000; res_dest = 1'b0; sat_mode = 1'b0; res_valid = 1'b1;
        sw_wdata = 16'h4200; sw_wr = 1'b1;
        @(posedge clk); #1;
        res_valid = 1'b0; sw_wr = 1'b0;
        model_wr(16'h4200);
        chk("R8 write wins", sw_rdata, exp_word());

        // R12: idle cycles with changing result inputs
        @(negedge clk);
        res_value = 41'h1FF_FFFF_FFFF; res_dest = 1'b1; sw_wdata = 16'hFFFF;
        repeat (4) @(negedge clk);
        chk("R12 idle hold", sw_rdata, exp_word());

        // pseudo-random results
        lf = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 400; k++) begin
            logic [40:0] v;
            int sh;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
            sh = int'(lf[63:58]) % 41;
            v  = 41'($signed(lf[40:0]) >>> sh);
            acc0_guard = lf[47:44]; acc1_guard = lf[51:48];
            do_op(v, lf[55], lf[56], "random");
        end

        // R11: exhaustive guard sweep
        for (int g = 0; g < 256; g++) begin
            acc0_guard = g[3:0]; acc1_guard = g[7:4];
            #1;
            chk("R11 guard sweep", sw_rdata, exp_word());
        end

        // R1: flags kept across reset, inputs ignored while held
        do_wr(16'hF210, "R1 preload");
        @(negedge clk);
        rst_n = 1'b0;
        res_value = 41'h0; res_valid = 1'b1; res_dest = 1'b0;
        sw_wdata = 16'h0000; sw_wr = 1'b1;
        repeat (3) @(negedge clk);
        res_valid = 1'b0; sw_wr = 1'b0;
        e_sl = 1'b0; e_sm = 1'b0;
        chk("R1 held in reset", sw_rdata, exp_word());
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 after reset", sw_rdata, exp_word());

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule